// File: doc/BRIEF.md
# Two-Operand NaN Result Selector

This block sits beside a floating-point datapath and decides what an operation returns when at least one of its two operands is a NaN. Each accepted input pair is checked for NaNs in single (binary32) or double (binary64) format. One operand's NaN is chosen under a selectable priority policy, and that NaN is made quiet if it was signaling. An invalid-operation flag is raised whenever a signaling NaN was present. The result, the flag and a valid strobe come out registered, one cycle after the inputs.

Two run-time controls set the behaviour. A signaling-bit mode states which value of the fraction's top bit marks a signaling NaN. A two-bit policy code picks one of three priority rules. One of these rules compares the two NaN payloads by magnitude and breaks a tie by sign. If neither operand is a NaN, the block does not claim the result, and the arithmetic path supplies it.

Top module: `nanpick_sel`

## Requirements
- R1: A value is a NaN when its exponent field is all ones and its fraction is nonzero. With `fmt_dbl`=0 only bits 31:0 are used (sign 31, exponent 30:23, fraction 22:0). With `fmt_dbl`=1 the layout is sign 63, exponent 62:52, fraction 51:0. The fraction's top bit is bit 22 or bit 51. A NaN is signaling when that bit equals `snan_msb_one`, and quiet otherwise.
- R2: `invalid` is 1 exactly when a valid result is produced and at least one operand is a signaling NaN.
- R3: Policy 2'b00 takes the first match of: a if signaling, b if signaling, a if quiet, otherwise b.
- R4: Policy 2'b01 returns a whenever a is any NaN, otherwise b.
- R5: Policy 2'b10 applies four rules. (1) If one operand is a signaling NaN and the other a quiet NaN, it returns the quiet one. (2) If both are NaNs of the same kind, it returns the one with the larger fraction field. (3) If a is a NaN and b is not, it returns a. (4) If a is not a NaN, it returns b.
- R6: Under policy 2'b10, when the fraction fields are equal, the result is the operand whose sign bit is 0 if only one has a 0 sign. Otherwise it is b.
- R7: Policy 2'b11 behaves exactly as policy 2'b00.
- R8: A chosen signaling NaN is quieted before output. With `snan_msb_one`=0, the fraction top bit is set and all other bits are kept. With `snan_msb_one`=1, the output is the default NaN: sign 0, exponent all ones, fraction top bit 0 and all other fraction bits 1 (0x7FBFFFFF or 0x7FF7FFFFFFFFFFFF). A quiet choice passes unchanged. In binary32, result bits 63:32 are 0.
- R9: If neither operand is a NaN, `out_valid` and `invalid` are 0 in the next cycle.
- R10: Outputs are registered, with one cycle from `in_valid` to `out_valid`. A cycle without `in_valid` gives `out_valid`=0, and reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| fmt_dbl | input | 1 | 0: binary32 in bits 31:0, 1: binary64 |
| snan_msb_one | input | 1 | Fraction top bit value that marks a signaling NaN |
| policy | input | 2 | Propagation priority rule select |
| op_a | input | 64 | Operand a |
| op_b | input | 64 | Operand b |
| out_valid | output | 1 | Result is a propagated NaN |
| result | output | 64 | Selected and quieted NaN |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The bench covers each policy with mixed signaling/quiet pairs. It checks policy 2'b11 against a pair where it differs from 2'b01, which catches a design that decodes the spare code as the wrong rule. The magnitude rule is driven with fractions that differ only in low bits, and with equal fractions of opposite sign in both operand orders. A design that compares with the sign included, or that ignores the sign on a tie, returns the negative NaN. Both signaling-bit modes are used. In the inverted mode, a design that sets the top bit instead of substituting the default NaN shows a wrong payload. Binary32 operands carry garbage in the upper half, so a design that classifies or passes the wrong half gives a wrong result. Infinities and numbers are checked to confirm that they never produce a valid strobe.

// File: rtl/nanpick_pkg.sv
package nanpick_pkg;

    parameter int DW  = 64;
    parameter int E32 = 8;
    parameter int F32 = 23;
    parameter int E64 = 11;
    parameter int F64 = 52;

    localparam int S32 = E32 + F32;
    localparam int S64 = E64 + F64;
    localparam int HI32 = DW - S32 - 1;

    typedef enum logic [1:0] {
        CLS_NUM  = 2'd0,
        CLS_QNAN = 2'd1,
        CLS_SNAN = 2'd2
    } nan_cls_e;

    typedef enum logic [1:0] {
        POL_SIG_FIRST = 2'd0,
        POL_A_FIRST   = 2'd1,
        POL_MAGNITUDE = 2'd2,
        POL_SPARE     = 2'd3
    } nan_pol_e;

    typedef struct packed {
        logic          valid;
        logic          invalid;
        logic          fmt_dbl;
        logic          msb_one;
        logic [DW-1:0] result;
    } nan_out_t;

endpackage

// File: rtl/nanpick_classify.sv
module nanpick_classify
    import nanpick_pkg::*;
(
    input  logic           [DW-1:0]  op,
    input  logic                     fmt_dbl,
    input  logic                     msb_one,
    output nan_cls_e                 cls,
    output logic           [F64-1:0] frac_key,
    output logic                     sign
);

    logic exp_ones;
    logic top_bit;
    logic is_nan;

    always_comb begin
        if (fmt_dbl) begin
            exp_ones = &op[S64-1:F64];
            frac_key = op[F64-1:0];
            top_bit  = op[F64-1];
            sign     = op[S64];
        end else begin
            exp_ones = &op[S32-1:F32];
            frac_key = {{(F64-F32){1'b0}}, op[F32-1:0]};
            top_bit  = op[F32-1];
            sign     = op[S32];
        end
        is_nan = exp_ones && (|frac_key);
        if (!is_nan) begin
            cls = CLS_NUM;
        end else if (top_bit == msb_one) begin
            cls = CLS_SNAN;
        end else begin
            cls = CLS_QNAN;
        end
    end

endmodule

// File: rtl/nanpick_policy.sv
module nanpick_policy
    import nanpick_pkg::*;
(
    input  nan_cls_e           cls_a,
    input  nan_cls_e           cls_b,
    input  logic     [F64-1:0] key_a,
    input  logic     [F64-1:0] key_b,
    input  logic               sign_a,
    input  logic               sign_b,
    input  logic     [1:0]     policy,
    output logic               pick_b,
    output logic               any_nan
);

    logic a_s, a_q, b_s, b_q;
    logic a_bigger;

    always_comb begin
        a_s = (cls_a == CLS_SNAN);
        a_q = (cls_a == CLS_QNAN);
        b_s = (cls_b == CLS_SNAN);
        b_q = (cls_b == CLS_QNAN);
        any_nan = a_s || a_q || b_s || b_q;

        // payload magnitude with sign-based tie break
        if (key_a != key_b) begin
            a_bigger = (key_a > key_b);
        end else begin
            a_bigger = !sign_a && sign_b;
        end

        unique case (nan_pol_e'(policy))
            POL_A_FIRST: begin
                pick_b = !(a_s || a_q);
            end
            POL_MAGNITUDE: begin
                if (a_s) begin
                    if (b_s) begin
                        pick_b = !a_bigger;
                    end else begin
                        pick_b = b_q;
                    end
                end else if (a_q) begin
                    if (b_q) begin
                        pick_b = !a_bigger;
                    end else begin
                        pick_b = 1'b0;
                    end
                end else begin
                    pick_b = 1'b1;
                end
            end
            default: begin
                if (a_s) begin
                    pick_b = 1'b0;
                end else if (b_s) begin
                    pick_b = 1'b1;
                end else if (a_q) begin
                    pick_b = 1'b0;
                end else begin
                    pick_b = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/nanpick_quiet.sv
module nanpick_quiet
    import nanpick_pkg::*;
(
    input  logic [DW-1:0] op,
    input  logic          fmt_dbl,
    input  logic          msb_one,
    input  logic          is_snan,
    output logic [DW-1:0] res
);

    localparam logic [DW-1:0] DFLT64 = {1'b0, {E64{1'b1}}, 1'b0, {(F64-1){1'b1}}};
    localparam logic [DW-1:0] DFLT32 = {{(HI32+1){1'b0}}, {E32{1'b1}}, 1'b0, {(F32-1){1'b1}}};

    always_comb begin
        if (fmt_dbl) begin
            res = op;
        end else begin
            res = {{(DW-S32-1){1'b0}}, op[S32:0]};
        end
        if (is_snan) begin
            if (msb_one) begin
                res = fmt_dbl ? DFLT64 : DFLT32;
            end else if (fmt_dbl) begin
                res[F64-1] = 1'b1;
            end else begin
                res[F32-1] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/nanpick_sel.sv
module nanpick_sel
    import nanpick_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          fmt_dbl,
    input  logic          snan_msb_one,
    input  logic [1:0]    policy,
    input  logic [63:0]   op_a,
    input  logic [63:0]   op_b,
    output logic          out_valid,
    output logic [63:0]   result,
    output logic          invalid
);

    localparam int NOPS = 2;

    logic     [DW-1:0]  ops    [NOPS];
    nan_cls_e           cls    [NOPS];
    logic     [F64-1:0] keys   [NOPS];
    logic               signs  [NOPS];

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar i = 0; i < NOPS; i++) begin : g_cls
        nanpick_classify u_cls (
            .op       (ops[i]),
            .fmt_dbl  (fmt_dbl),
            .msb_one  (snan_msb_one),
            .cls      (cls[i]),
            .frac_key (keys[i]),
            .sign     (signs[i])
        );
    end

    logic pick_b;
    logic any_nan;

    nanpick_policy u_pol (
        .cls_a   (cls[0]),
        .cls_b   (cls[1]),
        .key_a   (keys[0]),
        .key_b   (keys[1]),
        .sign_a  (signs[0]),
        .sign_b  (signs[1]),
        .policy  (policy),
        .pick_b  (pick_b),
        .any_nan (any_nan)
    );

    logic [DW-1:0] chosen;
    logic          chosen_snan;
    logic [DW-1:0] quieted;

    always_comb begin
        chosen      = pick_b ? op_b : op_a;
        chosen_snan = pick_b ? (cls[1] == CLS_SNAN) : (cls[0] == CLS_SNAN);
    end

    nanpick_quiet u_qt (
        .op      (chosen),
        .fmt_dbl (fmt_dbl),
        .msb_one (snan_msb_one),
        .is_snan (chosen_snan),
        .res     (quieted)
    );

    nan_out_t st_d, st_q;

    always_comb begin
        st_d         = '0;
        st_d.fmt_dbl = fmt_dbl;
        st_d.msb_one = snan_msb_one;
        if (in_valid && any_nan) begin
            st_d.valid   = 1'b1;
            st_d.invalid = (cls[0] == CLS_SNAN) || (cls[1] == CLS_SNAN);
            st_d.result  = quieted;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.result;
    assign invalid   = st_q.invalid;

    AST_INV_ON_SNAN: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (cls[0] == CLS_SNAN || cls[1] == CLS_SNAN) |=> invalid); // R2
    AST_NO_INV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cls[0] != CLS_SNAN && cls[1] != CLS_SNAN |=> !invalid); // R2
    AST_NONAN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cls[0] == CLS_NUM && cls[1] == CLS_NUM |=> !out_valid); // R9
    AST_IDLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !invalid); // R10
    AST_P1_TAKES_A: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && policy == 2'b01 && cls[0] != CLS_NUM |-> !pick_b); // R4
    AST_P2_QUIET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && policy == 2'b10 && cls[0] == CLS_SNAN && cls[1] == CLS_QNAN |-> pick_b); // R5
    AST_OUT_QUIET32: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !st_q.fmt_dbl && !st_q.msb_one |-> (&result[30:23]) && result[22]
        && (result[63:32] == '0)); // R8

endmodule

// File: tb/tb_nanpick_sel.sv
module tb_nanpick_sel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        fmt_dbl = 1'b0;
    logic        snan_msb_one = 1'b0;
    logic [1:0]  policy = 2'b00;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        invalid;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    nanpick_sel dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_dbl(fmt_dbl),
        .snan_msb_one(snan_msb_one), .policy(policy), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .result(result), .invalid(invalid)
    );

    task automatic check(input string tag, input logic ev, input logic [63:0] er, input logic ei);
        n_checks++;
        if (out_valid !== ev || invalid !== ei || (ev && result !== er)) begin
            n_fails++;
            $display("FAIL %s: got v=%0b r=%h i=%0b, expected v=%0b r=%h i=%0b",
                     tag, out_valid, result, invalid, ev, er, ei);
        end
    endtask

    task automatic run(input logic [63:0] a, input logic [63:0] b, input logic dbl,
                       input logic mode, input logic [1:0] pol);
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b; fmt_dbl = dbl; snan_msb_one = mode; policy = pol;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R10 reset", 1'b0, 64'h0, 1'b0);
    endtask

    task automatic t_sig_first;   // R3 R2
        run(64'h7FC00011, 64'h7F800022, 0, 0, 2'b00); check("R3 q/s", 1, 64'h7FC00022, 1);
        run(64'h7F800033, 64'hFF800044, 0, 0, 2'b00); check("R3 s/s", 1, 64'h7FC00033, 1);
        run(64'h7FC00055, 64'h7FC00066, 0, 0, 2'b00); check("R3 q/q", 1, 64'h7FC00055, 0);
        run(64'h3F800000, 64'hFFC00077, 0, 0, 2'b00); check("R3 n/q", 1, 64'hFFC00077, 0);
    endtask

    task automatic t_a_first;     // R4
        run(64'h7FC00011, 64'h7F800022, 0, 0, 2'b01); check("R4 q/s", 1, 64'h7FC00011, 1);
        run(64'h3F800000, 64'h7F800022, 0, 0, 2'b01); check("R4 n/s", 1, 64'h7FC00022, 1);
    endtask

    task automatic t_magnitude;   // R5
        run(64'h7F800100, 64'h7FC00001, 0, 0, 2'b10); check("R5 s/q", 1, 64'h7FC00001, 1);
        run(64'h7FC00001, 64'h7F800100, 0, 0, 2'b10); check("R5 q/s", 1, 64'h7FC00001, 1);
        run(64'h7F800100, 64'h7F800200, 0, 0, 2'b10); check("R5 s/s", 1, 64'h7FC00200, 1);
        run(64'h7FC00300, 64'h7FC00200, 0, 0, 2'b10); check("R5 q/q", 1, 64'h7FC00300, 0);
        run(64'h7F800005, 64'h40000000, 0, 0, 2'b10); check("R5 s/n", 1, 64'h7FC00005, 1);
        run(64'h40000000, 64'hFFC00009, 0, 0, 2'b10); check("R5 n/q", 1, 64'hFFC00009, 0);
        run(64'h7FF0000000001000, 64'h7FF0000000000FFF, 1, 0, 2'b10);
        check("R5 dbl s/s", 1, 64'h7FF8000000001000, 1);
    endtask

    task automatic t_tie;         // R6
        run(64'hFFC00010, 64'h7FC00010, 0, 0, 2'b10); check("R6 neg/pos", 1, 64'h7FC00010, 0);
        run(64'h7FC00010, 64'hFFC00010, 0, 0, 2'b10); check("R6 pos/neg", 1, 64'h7FC00010, 0);
        run(64'hFF800010, 64'h7F800010, 0, 0, 2'b10); check("R6 s tie", 1, 64'h7FC00010, 1);
    endtask

    task automatic t_spare;       // R7
        run(64'h7FC00011, 64'h7F800022, 0, 0, 2'b11); check("R7 spare", 1, 64'h7FC00022, 1);
    endtask

    task automatic t_quiet_modes; // R8 R1
        run(64'h7FC00123, 64'h7F800001, 0, 1, 2'b00); check("R8 m1 dflt32", 1, 64'h7FBFFFFF, 1);
        run(64'h7F800456, 64'h3F800000, 0, 1, 2'b01); check("R1 m1 quiet", 1, 64'h7F800456, 0);
        run(64'h7FC00000, 64'h3F800000, 0, 1, 2'b01); check("R1 m1 msb only", 1, 64'h7FBFFFFF, 1);
        run(64'h7FF8000000000ABC, 64'hFFF0000000000DEF, 1, 0, 2'b00);
        check("R8 dbl m0", 1, 64'hFFF8000000000DEF, 1);
        run(64'h7FF8000000000000, 64'h3FF0000000000000, 1, 1, 2'b01);
        check("R8 m1 dflt64", 1, 64'h7FF7FFFFFFFFFFFF, 1);
        run(64'hDEADBEEF7FC00011, 64'h0, 0, 0, 2'b00); check("R8 upper zero", 1, 64'h7FC00011, 0);
    endtask

    task automatic t_no_nan;      // R9 R1
        run(64'h7F800000, 64'h3F800000, 0, 0, 2'b00); check("R9 inf", 0, 64'h0, 0);
        run(64'h7FF8000000000000, 64'h7FF0000000000000, 0, 0, 2'b10); check("R1 low half", 0, 64'h0, 0);
        run(64'h7FF0000000000000, 64'h3FF0000000000000, 1, 0, 2'b01); check("R9 dbl inf", 0, 64'h0, 0);
    endtask

    task automatic t_idle;        // R10
        @(negedge clk);
        in_valid = 1'b0; op_a = 64'h7F800001; op_b = 64'h7F800002; fmt_dbl = 0;
        @(posedge clk);
        #1;
        check("R10 idle", 0, 64'h0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #3;
        t_reset();
        repeat (2) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_sig_first();
        t_a_first();
        t_magnitude();
        t_tie();
        t_spare();
        t_quiet_modes();
        t_no_nan();
        t_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule